// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block produces the horizontal and vertical timing of a digital composite video encoder clocked at 13.5 MHz. One input picks the standard: 525-line 60 Hz (`std_sel` = 0) or 625-line 50 Hz (`std_sel` = 1). From a pixel counter and a line counter it derives these signals:

- a composite sync flag
- a blanking flag and a colour-burst gate
- a field flag
- a one-clock vertical-sync marker
- a signed sync-level code that the luma path adds to its samples

The vertical interval is tracked in half-line steps. A four-state machine walks through it: `PH_ACTIVE`, `PH_PRE_EQ`, `PH_BROAD` and `PH_POST_EQ`. The transitions are:

- `PH_ACTIVE` to `PH_PRE_EQ` when the half-line index reaches the start of either field's interval.
- `PH_PRE_EQ` to `PH_BROAD` after N half-lines.
- `PH_BROAD` to `PH_POST_EQ` after 2N half-lines.
- `PH_POST_EQ` back to `PH_ACTIVE` after 3N half-lines.

N is 6 for 525 lines and 5 for 625 lines. Field 1's interval starts at half 0 of line `VSTART` (default 3, counting lines from 0). Field 2's interval starts one odd line count of half-lines later, which gives the interlace offset. A change of `std_sel` is latched only when the frame wraps.

Top module: `video_sync_gen`

## Requirements
- R1: `hcount` counts 0..857 in 525-line mode and 0..863 in 625-line mode, then returns to 0.
- R2: `line` advances when `hcount` wraps and returns to 0 after `NTSC_LINES` lines (default 525) or `PAL_LINES` lines (default 625).
- R3: On a line with no vertical-interval half-line, `csync` is high for `hcount` 0..63 only. On such lines `burst` is high for 72..106 in 525-line mode and 76..107 in 625-line mode. `burst` is never high on lines that touch the vertical interval.
- R4: `blank` is high when `hcount` < 127 or `hcount` >= 837 in 525-line mode, and when `hcount` < 142 or `hcount` >= 844 in 625-line mode. It is also high for the whole of any line that contains a vertical-interval half-line.
- R5: Each equalizing half-line has a pulse measured from its own start, of offsets 0..31 in 525-line mode or 0..32 in 625-line mode. The second half of a line starts at count 429 or 432 respectively.
- R6: Each broad half-line has a pulse of offsets 0..366 in 525-line mode or 0..368 in 625-line mode, measured from its half start.
- R7: The half-line index is 2·`line` + (second half). The interval begins at index 2·`VSTART` and at 2·`VSTART` + line count. In order, it holds N pre-equalizing, N broad and N post-equalizing half-lines, with N = 6 (525) or N = 5 (625).
- R8: `field` is high from the first interval start up to the second interval start, and low otherwise. It therefore changes only at an interval start.
- R9: `vsync` is high for exactly one clock, at offset 0 of the first post-equalizing half-line.
- R10: `sync_level` is a signed code in half-IRE units:
  - −80 (525-line mode) or −86 (625-line mode) while `csync` is high;
  - +15 in 525-line mode while neither `csync` nor `blank` is high;
  - 0 otherwise.
- R11: A new value of `std_sel` takes effect only at the clock where `hcount` and `line` both return to 0.
- R12: Synchronous reset sets `hcount` and `line` to 0 and loads the standard from `std_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz pixel clock |
| rst | input | 1 | synchronous reset, active high |
| std_sel | input | 1 | standard request: 0 = 525-line, 1 = 625-line |
| csync | output | 1 | composite sync flag |
| blank | output | 1 | blanking flag |
| burst | output | 1 | colour-burst gate |
| hcount | output | HW | pixel position in the line |
| line | output | LW | line position in the frame |
| field | output | 1 | field flag |
| vsync | output | 1 | one-clock vertical-sync marker |
| sync_level | output | 8 | signed sync/setup code for the luma path |

## Verification
The bench builds the block with `NTSC_LINES` = 25 and `PAL_LINES` = 27, keeping every horizontal count at its full value. Those odd short frames still hold both fields' complete vertical intervals and the interlace offset. They bring many frame wraps within reach, and with them standard switches requested mid-frame as well as a reset taken in the middle of a run. The real pixel counts keep every pulse edge at its true position.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int TW = 10;

    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_PRE_EQ,
        PH_BROAD,
        PH_POST_EQ
    } vphase_t;

    typedef struct packed {
        logic [TW-1:0]      htotal;
        logic [TW-1:0]      half;
        logic [TW-1:0]      hs_end;
        logic [TW-1:0]      eq_end;
        logic [TW-1:0]      br_end;
        logic [TW-1:0]      bg_start;
        logic [TW-1:0]      bg_end;
        logic [TW-1:0]      act_start;
        logic [TW-1:0]      fp_start;
        logic [3:0]         npulse;
        logic signed [7:0]  tip;
        logic signed [7:0]  setup;
    } htiming_t;

    // Horizontal constants in 13.5 MHz cycles; levels in half-IRE.
    function automatic htiming_t vsg_timing(input logic pal);
        htiming_t t;
        if (pal) begin
            t.htotal = 10'd864;  t.half = 10'd432;    t.hs_end = 10'd63;
            t.eq_end = 10'd32;   t.br_end = 10'd368;  t.bg_start = 10'd76;
            t.bg_end = 10'd107;  t.act_start = 10'd142; t.fp_start = 10'd844;
            t.npulse = 4'd5;     t.tip = -8'sd86;     t.setup = 8'sd0;
        end else begin
            t.htotal = 10'd858;  t.half = 10'd429;    t.hs_end = 10'd63;
            t.eq_end = 10'd31;   t.br_end = 10'd366;  t.bg_start = 10'd72;
            t.bg_end = 10'd106;  t.act_start = 10'd127; t.fp_start = 10'd837;
            t.npulse = 4'd6;     t.tip = -8'sd80;     t.setup = 8'sd15;
        end
        return t;
    endfunction

endpackage

// File: rtl/vsg_counters.sv
module vsg_counters
    import vsg_pkg::*;
#(
    parameter int HW         = 10,
    parameter int LW         = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          std_sel,
    output logic [HW-1:0] hcount,
    output logic [LW-1:0] line,
    output logic          pal,
    output logic [HW-1:0] h_nx,
    output logic [LW-1:0] l_nx,
    output logic          pal_nx
);
    localparam logic [LW-1:0] NTSC_LAST = LW'(NTSC_LINES - 1);
    localparam logic [LW-1:0] PAL_LAST  = LW'(PAL_LINES - 1);

    htiming_t t;
    logic     h_last;
    logic     l_last;

    always_comb begin
        t      = vsg_timing(pal);
        h_last = (hcount == HW'(t.htotal - 10'd1));
        l_last = (line == (pal ? PAL_LAST : NTSC_LAST));
        h_nx   = h_last ? '0 : hcount + HW'(1);
        l_nx   = h_last ? (l_last ? '0 : line + LW'(1)) : line;
        pal_nx = (h_last && l_last) ? std_sel : pal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcount <= '0;
            line   <= '0;
            pal    <= std_sel;
        end else begin
            hcount <= h_nx;
            line   <= l_nx;
            pal    <= pal_nx;
        end
    end

endmodule

// File: rtl/vsg_vphase.sv
module vsg_vphase
    import vsg_pkg::*;
#(
    parameter int HW         = 10,
    parameter int LW         = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625,
    parameter int VSTART     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h_nx,
    input  logic [LW-1:0] l_nx,
    input  logic          pal_nx,
    output vphase_t       phase
);
    localparam int XW = LW + 1;

    htiming_t      t;
    logic [XW-1:0] s1, s2, np, hidx, off;
    vphase_t       phase_nx;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_ACTIVE;
        else     phase <= phase_nx;
    end

    always_comb begin
        t    = vsg_timing(pal_nx);
        s1   = XW'(2 * VSTART);
        s2   = s1 + (pal_nx ? XW'(PAL_LINES) : XW'(NTSC_LINES));
        np   = XW'(t.npulse);
        hidx = {l_nx, 1'b0} + XW'(h_nx >= HW'(t.half));
        off  = hidx - ((hidx >= s2) ? s2 : s1);
        phase_nx = phase;
        unique case (phase)
            PH_ACTIVE:  if (hidx == s1 || hidx == s2) phase_nx = PH_PRE_EQ;
            PH_PRE_EQ:  if (off == np)                phase_nx = PH_BROAD;
            PH_BROAD:   if (off == XW'(2) * np)       phase_nx = PH_POST_EQ;
            PH_POST_EQ: if (off == XW'(3) * np)       phase_nx = PH_ACTIVE;
        endcase
    end

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int HW         = 10,
    parameter int LW         = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625,
    parameter int VSTART     = 3
) (
    input  logic [HW-1:0]     hcount,
    input  logic [LW-1:0]     line,
    input  logic              pal,
    input  vphase_t           phase,
    output logic              csync,
    output logic              blank,
    output logic              burst,
    output logic              field,
    output logic              vsync,
    output logic signed [7:0] sync_level
);
    localparam int XW = LW + 1;

    htiming_t      t;
    logic [XW-1:0] s1, s2, n3, hidx, l0, l1, post1, post2;
    logic [HW-1:0] hr;
    logic          upper, vline;

    always_comb begin
        t     = vsg_timing(pal);
        s1    = XW'(2 * VSTART);
        s2    = s1 + (pal ? XW'(PAL_LINES) : XW'(NTSC_LINES));
        n3    = XW'(3) * XW'(t.npulse);
        post1 = s1 + XW'(2) * XW'(t.npulse);
        post2 = s2 + XW'(2) * XW'(t.npulse);
        upper = hcount >= HW'(t.half);
        hr    = upper ? hcount - HW'(t.half) : hcount;
        hidx  = {line, upper};
        l0    = {line, 1'b0};
        l1    = {line, 1'b1};
        vline = (l0 >= s1 && l0 < s1 + n3) || (l0 >= s2 && l0 < s2 + n3) ||
                (l1 >= s1 && l1 < s1 + n3) || (l1 >= s2 && l1 < s2 + n3);

        unique case (phase)
            PH_ACTIVE:  csync = !upper && hcount <= HW'(t.hs_end);
            PH_PRE_EQ,
            PH_POST_EQ: csync = hr <= HW'(t.eq_end);
            PH_BROAD:   csync = hr <= HW'(t.br_end);
        endcase

        blank = vline || hcount < HW'(t.act_start) || hcount >= HW'(t.fp_start);
        burst = !vline && hcount >= HW'(t.bg_start) && hcount <= HW'(t.bg_end);
        field = hidx >= s1 && hidx < s2;
        vsync = (hr == '0) && (hidx == post1 || hidx == post2);

        if (csync)       sync_level = t.tip;
        else if (!blank) sync_level = t.setup;
        else             sync_level = 8'sd0;
    end

endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
    import vsg_pkg::*;
#(
    parameter int HW         = 10,
    parameter int LW         = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625,
    parameter int VSTART     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_sel,
    output logic              csync,
    output logic              blank,
    output logic              burst,
    output logic [HW-1:0]     hcount,
    output logic [LW-1:0]     line,
    output logic              field,
    output logic              vsync,
    output logic signed [7:0] sync_level
);
    logic          pal_q, pal_nx;
    logic [HW-1:0] h_nx;
    logic [LW-1:0] l_nx;
    vphase_t       phase;

    vsg_counters #(.HW(HW), .LW(LW), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES)) u_cnt (
        .clk(clk), .rst(rst), .std_sel(std_sel),
        .hcount(hcount), .line(line), .pal(pal_q),
        .h_nx(h_nx), .l_nx(l_nx), .pal_nx(pal_nx)
    );

    vsg_vphase #(.HW(HW), .LW(LW), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
                 .VSTART(VSTART)) u_vph (
        .clk(clk), .rst(rst), .h_nx(h_nx), .l_nx(l_nx), .pal_nx(pal_nx), .phase(phase)
    );

    vsg_decode #(.HW(HW), .LW(LW), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
                 .VSTART(VSTART)) u_dec (
        .hcount(hcount), .line(line), .pal(pal_q), .phase(phase),
        .csync(csync), .blank(blank), .burst(burst), .field(field),
        .vsync(vsync), .sync_level(sync_level)
    );

endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
    parameter int HW = 10,
    parameter int LW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              pal_q,
    input logic              csync,
    input logic              blank,
    input logic              burst,
    input logic [HW-1:0]     hcount,
    input logic [LW-1:0]     line,
    input logic              field,
    input logic              vsync,
    input logic signed [7:0] sync_level
);
    logic [HW-1:0] h_last;
    assign h_last = pal_q ? HW'(863) : HW'(857);

    AST_HCOUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (hcount == h_last) |=> (hcount == '0)); // R1

    AST_HCOUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (hcount != h_last) |=> (hcount == $past(hcount) + HW'(1))); // R1

    AST_BURST_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        burst |-> (blank && !csync)); // R3

    AST_FIELD_AT_PULSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(field) |-> csync); // R8

    AST_VSYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vsync |=> !vsync); // R9

    AST_TIP_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
        csync |-> (sync_level < 0)); // R10

    AST_STD_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !(hcount == '0 && line == '0) |-> $stable(pal_q)); // R11

endmodule

bind video_sync_gen vsg_checker #(.HW(HW), .LW(LW)) u_vsg_chk (
    .clk(clk), .rst(rst), .pal_q(pal_q), .csync(csync), .blank(blank),
    .burst(burst), .hcount(hcount), .line(line), .field(field),
    .vsync(vsync), .sync_level(sync_level)
);

// File: tb/video_sync_gen_bench.sv
`timescale 1ns/1ps
module video_sync_gen_bench;
    localparam int NL = 25;
    localparam int PL = 27;
    localparam int VS = 3;
    localparam int CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_sel = 1'b0;
    logic csync, blank, burst, field, vsync;
    logic [9:0] hcount, line;
    logic signed [7:0] sync_level;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    video_sync_gen #(.HW(10), .LW(10), .NTSC_LINES(NL), .PAL_LINES(PL), .VSTART(VS)) u_video_sync_gen (
        .clk(clk), .rst(rst), .std_sel(std_sel), .csync(csync), .blank(blank),
        .burst(burst), .hcount(hcount), .line(line), .field(field),
        .vsync(vsync), .sync_level(sync_level)
    );

    // 0 normal, 1 equalizing, 2 broad
    function automatic int htype(input int hi, input int s1, input int s2, input int n);
        int o;
        for (int k = 0; k < 2; k++) begin
            o = hi - ((k == 0) ? s1 : s2);
            if ((o >= 0 && o < n) || (o >= 2*n && o < 3*n)) return 1;
            if (o >= n && o < 2*n) return 2;
        end
        return 0;
    endfunction

    function automatic void model(input bit pal, input int h, input int l,
                                  output bit cs, output bit bl, output bit bu,
                                  output bit fl, output bit vs, output int lv,
                                  output int kind);
        int half, n, s1, s2, hi, hr;
        bit up, vl;
        half = pal ? 432 : 429;
        n    = pal ? 5 : 6;
        s1   = 2 * VS;
        s2   = s1 + (pal ? PL : NL);
        up   = (h >= half);
        hr   = up ? h - half : h;
        hi   = 2 * l + (up ? 1 : 0);
        kind = htype(hi, s1, s2, n);
        vl   = (htype(2*l, s1, s2, n) != 0) || (htype(2*l+1, s1, s2, n) != 0);
        if (kind == 0)      cs = !up && h <= 63;
        else if (kind == 1) cs = hr <= (pal ? 32 : 31);
        else                cs = hr <= (pal ? 368 : 366);
        bl = vl || h < (pal ? 142 : 127) || h >= (pal ? 844 : 837);
        bu = !vl && h >= (pal ? 76 : 72) && h <= (pal ? 107 : 106);
        fl = hi >= s1 && hi < s2;
        vs = (hr == 0) && (hi == s1 + 2*n || hi == s2 + 2*n);
        lv = cs ? (pal ? -86 : -80) : ((!bl && !pal) ? 15 : 0);
    endfunction

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        bit  m_pal, e_cs, e_bl, e_bu, e_fl, e_vs, bad;
        int  m_h, m_l, e_lv, kind;
        string ctag;
        void'($urandom(32'd20240));
        m_pal = 1'b0; m_h = 0; m_l = 0;
        @(posedge clk);
        for (int c = 0; c < CYCLES; c++) begin
            @(negedge clk);
            model(m_pal, m_h, m_l, e_cs, e_bl, e_bu, e_fl, e_vs, e_lv, kind);
            bad = 1'b0;
            ctag = (kind == 0) ? "R3" : ((kind == 1) ? "R5" : "R6");
            if (c == 0 && (hcount != 0 || line != 0)) begin
                bad = 1'b1;
                $display("FAIL R12 reset state: actual h=%0d l=%0d expected h=0 l=0", hcount, line);
            end
            if (int'(hcount) != m_h) begin
                bad = 1'b1;
                $display("FAIL R1/R11 hcount: actual=%0d expected=%0d", hcount, m_h);
            end
            if (int'(line) != m_l) begin
                bad = 1'b1;
                $display("FAIL R2 line: actual=%0d expected=%0d", line, m_l);
            end
            if (csync != e_cs) begin
                bad = 1'b1;
                $display("FAIL %s csync at l=%0d h=%0d: actual=%0b expected=%0b", ctag, m_l, m_h, csync, e_cs);
            end
            if (blank != e_bl) begin
                bad = 1'b1;
                $display("FAIL R4 blank at l=%0d h=%0d: actual=%0b expected=%0b", m_l, m_h, blank, e_bl);
            end
            if (burst != e_bu) begin
                bad = 1'b1;
                $display("FAIL R3 burst at l=%0d h=%0d: actual=%0b expected=%0b", m_l, m_h, burst, e_bu);
            end
            if (field != e_fl) begin
                bad = 1'b1;
                $display("FAIL R8 field at l=%0d h=%0d: actual=%0b expected=%0b", m_l, m_h, field, e_fl);
            end
            if (vsync != e_vs) begin
                bad = 1'b1;
                $display("FAIL R9 vsync at l=%0d h=%0d: actual=%0b expected=%0b", m_l, m_h, vsync, e_vs);
            end
            if (int'(sync_level) != e_lv) begin
                bad = 1'b1;
                $display("FAIL R10 level at l=%0d h=%0d: actual=%0d expected=%0d", m_l, m_h, sync_level, e_lv);
            end
            // R7: first clock of field 1 interval must open an equalizing pulse
            if (m_l == VS && m_h == 0 && !(csync && field)) begin
                bad = 1'b1;
                $display("FAIL R7 interval start: actual cs=%0b fl=%0b expected cs=1 fl=1", csync, field);
            end
            vectors++;
            if (bad) fails++;

            // next inputs
            rst = (c < 2) || (c >= 100000 && c < 100003);
            if (c == 30000) std_sel = 1'b1;        // mid-frame request, R11
            if (c == 60000) std_sel = 1'b0;
            if (c == 99999) std_sel = 1'b1;        // reset loads it, R12
            if (c > 110000 && ($urandom % 6000) == 0) std_sel = ~std_sel;

            // advance model
            if (rst) begin
                m_h = 0; m_l = 0; m_pal = std_sel;
            end else if (m_h == (m_pal ? 863 : 857)) begin
                m_h = 0;
                if (m_l == (m_pal ? PL : NL) - 1) begin
                    m_l = 0; m_pal = std_sel;
                end else begin
                    m_l++;
                end
            end else begin
                m_h++;
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule